// File: doc/BRIEF.md
# Multi-Channel DMA Run/Stop Sequencer

This block keeps the run-control side of a multi-channel memory-to-memory mover. Each channel has a control word that software writes to start the channel, stop it or clear it. The channel also has a two-bit state field that software polls to learn when a request has taken effect. A stop or clear that arrives while the mover is in the middle of a transfer on that channel does not cut the transfer short. The run permission drops at once, the state keeps reading busy until the mover reports the channel quiet, and only then does the state change to stopped or cleared.

Each channel also has a descriptor window, given as a first index and a final index, and a one-bit priority. The block tracks how many descriptors are queued in the window. It accepts new descriptors only while the channel runs and the window has room. It empties the count when a clear takes effect and reports a full flag when the count reaches the window size. The registers are reached through a simple write port and a read port. The read port returns data one cycle after the address is presented.

Top module: `dcc_top`

## Requirements
- R1: After reset every channel reports state 3 (cleared), its run output is low, its priority is 0, its window indices are 0 and its queue is empty, so the full flag is low.
- R2: The register address is {channel, select}. The low two bits are the select: 0 = first index, 1 = final index, 2 = priority, 3 = control. rd_data returns the addressed register one clock after rd_addr is presented, with all unused bits read as 0. A write changes only the addressed channel.
- R3: The control word reads bit 0 = run, bit 1 = clear pending, bit 8 = full and bits 10:9 = state. The state codes are 0 idle, 1 busy, 2 stopped and 3 cleared.
- R4: A control write with bit 0 = 1 and bit 1 = 0 raises run on that clock edge. On the same edge the state becomes 1 if the channel's busy input is high and 0 if it is low. While the state is 2 or 3, run is low.
- R5: While run is high and no control write occurs, the state at each edge is 1 if busy was high at that edge and 0 otherwise.
- R6: A control write with bit 0 = 0 and bit 1 = 0 drops run on that edge. If busy is high, the state stays 1 until the first edge that samples busy low, and it becomes 2 on that edge. If busy is low, the state becomes 2 at once.
- R7: A control write with bit 1 = 1 drops run and, while busy is high, sets clear pending and holds state 1. At the first edge with busy low, the state becomes 3, clear pending drops and the queue count goes to 0. State 3 then holds until the next control write.
- R8: A control write with bit 0 = 1 and bit 1 = 0 made while a stop or clear is still pending cancels it. Once busy falls, the state returns to 0, not 2 or 3.
- R9: A push is counted only when run is high and the queue is not full. A pop decrements the count only when it is non-zero. Full is high when count >= final - first + 1, or always when final < first. Pushes made while run is low are ignored.
- R10: prio_o of a channel equals bit 0 of the last priority write to that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_W+2 | Write address {channel, select} |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | CH_W+2 | Read address {channel, select} |
| rd_data | output | DATA_W | Registered read data |
| busy_i | input | NUM_CH | Per-channel transfer-in-flight indication from the mover |
| push_i | input | NUM_CH | Per-channel descriptor enqueue pulse |
| pop_i | input | NUM_CH | Per-channel descriptor completion pulse |
| run_o | output | NUM_CH | Per-channel permission for the mover to start work |
| state_o | output | 2*NUM_CH | Per-channel state, channel c in bits 2c+1:2c |
| full_o | output | NUM_CH | Per-channel queue full flag |
| prio_o | output | NUM_CH | Per-channel priority bit |

## Verification
The bench targets the deferred paths: a stop or clear issued while busy is high, with checks that the state still reads busy before the mover goes quiet. A design that completed the request at once would show stopped or cleared too early, and one that never looked at busy again would stay busy forever. A restart issued during a drain must end in idle. A design that forgets to cancel the pending request would report stopped. The queue checks push into a full window and push while the channel is halted, then pop and refill. A design that counted the dropped pushes would report full too long, or full too early after the restart.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_STOP = 2'd2,
    ST_CLR  = 2'd3
  } ch_state_e;

  localparam logic [1:0] SEL_FIRST = 2'd0;
  localparam logic [1:0] SEL_FINAL = 2'd1;
  localparam logic [1:0] SEL_PRIO  = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_CLR   = 1;
  localparam int unsigned BIT_FULL  = 8;
  localparam int unsigned BIT_STATE = 9;
endpackage

// File: rtl/dcc_chan_fsm.sv
module dcc_chan_fsm
  import dcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ctl_wr,
  input  logic      ctl_run,
  input  logic      ctl_clr,
  input  logic      busy_i,
  output logic      run_o,
  output logic      pend_o,
  output logic      clear_o,
  output ch_state_e state_o
);
  logic      run_q;
  logic      pend_q;
  ch_state_e state_q;
  logic      drain_done;

  // channel halted while a transfer was in flight, and the mover is now quiet
  assign drain_done = !run_q && (state_q == ST_BUSY) && !busy_i;

  always_comb begin
    if (ctl_wr) clear_o = ctl_clr && !busy_i;
    else        clear_o = drain_done && pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      state_q <= ST_CLR;
    end else if (ctl_wr) begin
      if (ctl_clr) begin
        run_q   <= 1'b0;
        pend_q  <= busy_i;
        state_q <= busy_i ? ST_BUSY : ST_CLR;
      end else if (ctl_run) begin
        run_q   <= 1'b1;
        pend_q  <= 1'b0;
        state_q <= busy_i ? ST_BUSY : ST_IDLE;
      end else begin
        run_q   <= 1'b0;
        pend_q  <= 1'b0;
        state_q <= busy_i ? ST_BUSY : ST_STOP;
      end
    end else if (run_q) begin
      state_q <= busy_i ? ST_BUSY : ST_IDLE;
    end else if (drain_done) begin
      state_q <= pend_q ? ST_CLR : ST_STOP;
      pend_q  <= 1'b0;
    end
  end

  assign run_o   = run_q;
  assign pend_o  = pend_q;
  assign state_o = state_q;

  p_follow_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && !ctl_wr && !busy_i) |=> (state_q == ST_IDLE));

  p_hold_busy_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && state_q == ST_BUSY && busy_i && !ctl_wr) |=> (state_q == ST_BUSY));

  p_clear_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CLR && !ctl_wr) |=> (state_q == ST_CLR));

  p_halt_no_run_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP || state_q == ST_CLR) |-> !run_q);

  p_pend_only_drain_r7: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (state_q == ST_BUSY && !run_q));
endmodule

// File: rtl/dcc_ring_occ.sv
module dcc_ring_occ #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] first_i,
  input  logic [IDX_W-1:0] final_i,
  output logic             full_o
);
  localparam int unsigned OCC_W = IDX_W + 1;

  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] cap;
  logic             full;
  logic             push_ok;
  logic             pop_ok;

  always_comb begin
    if (final_i >= first_i) cap = {1'b0, final_i} - {1'b0, first_i} + OCC_W'(1);
    else                    cap = '0;
  end

  assign full    = (occ_q >= cap);
  assign push_ok = run_i && push_i && !full;
  assign pop_ok  = pop_i && (occ_q != '0);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      occ_q <= '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign full_o = full;

  p_halted_push_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !pop_i && !clear_i) |=> $stable(occ_q));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0 && !push_i) |=> (occ_q == '0));
endmodule

// File: rtl/dcc_top.sv
module dcc_top
  import dcc_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned AW    = CH_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_CH-1:0]   busy_i,
  input  logic [NUM_CH-1:0]   push_i,
  input  logic [NUM_CH-1:0]   pop_i,
  output logic [NUM_CH-1:0]   run_o,
  output logic [2*NUM_CH-1:0] state_o,
  output logic [NUM_CH-1:0]   full_o,
  output logic [NUM_CH-1:0]   prio_o
);
  logic [IDX_W-1:0]  first_q [NUM_CH];
  logic [IDX_W-1:0]  final_q [NUM_CH];
  logic [NUM_CH-1:0] prio_q;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] clear;
  ch_state_e         st [NUM_CH];
  logic [DATA_W-1:0] rd_q;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data;

  wire [CH_W-1:0] wr_ch  = wr_addr[AW-1:2];
  wire [1:0]      wr_sel = wr_addr[1:0];
  wire [CH_W-1:0] rd_ch  = rd_addr[AW-1:2];
  wire [1:0]      rd_sel = rd_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        first_q[c] <= '0;
        final_q[c] <= '0;
        prio_q[c]  <= 1'b0;
      end else if (hit) begin
        if (wr_sel == SEL_FIRST) first_q[c] <= wr_data[IDX_W-1:0];
        if (wr_sel == SEL_FINAL) final_q[c] <= wr_data[IDX_W-1:0];
        if (wr_sel == SEL_PRIO)  prio_q[c]  <= wr_data[0];
      end
    end

    dcc_chan_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .ctl_wr  (hit && (wr_sel == SEL_CTRL)),
      .ctl_run (wr_data[BIT_RUN]),
      .ctl_clr (wr_data[BIT_CLR]),
      .busy_i  (busy_i[c]),
      .run_o   (run_o[c]),
      .pend_o  (pend[c]),
      .clear_o (clear[c]),
      .state_o (st[c])
    );

    dcc_ring_occ #(.IDX_W(IDX_W)) u_occ (
      .clk     (clk),
      .rst     (rst),
      .run_i   (run_o[c]),
      .clear_i (clear[c]),
      .push_i  (push_i[c]),
      .pop_i   (pop_i[c]),
      .first_i (first_q[c]),
      .final_i (final_q[c]),
      .full_o  (full_o[c])
    );

    assign state_o[2*c +: 2] = st[c];
  end

  assign prio_o = prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (int'(rd_ch) >= NUM_CH) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      case (rd_sel)
        SEL_FIRST: rd_q[IDX_W-1:0] <= first_q[rd_ch];
        SEL_FINAL: rd_q[IDX_W-1:0] <= final_q[rd_ch];
        SEL_PRIO:  rd_q[0]         <= prio_q[rd_ch];
        default: begin
          rd_q[BIT_RUN]            <= run_o[rd_ch];
          rd_q[BIT_CLR]            <= pend[rd_ch];
          rd_q[BIT_FULL]           <= full_o[rd_ch];
          rd_q[BIT_STATE +: 2]     <= st[rd_ch];
        end
      endcase
    end
  end

  assign rd_data = rd_q;

  p_prio_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_PRIO && int'(wr_ch) < NUM_CH) |=> (prio_o[$past(wr_ch)] == $past(wr_data[0])));
endmodule

// File: tb/dcc_top_tb_top.sv
`timescale 1ns/1ps
module dcc_top_tb_top;
  localparam int NUM_CH = 4;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int AW     = 4;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NUM_CH-1:0] busy_i, push_i, pop_i, run_o, full_o, prio_o;
  logic [2*NUM_CH-1:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dcc_top #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy_i(busy_i), .push_i(push_i),
    .pop_i(pop_i), .run_o(run_o), .state_o(state_o), .full_o(full_o), .prio_o(prio_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int st, input bit full, input bit pend, input bit run);
    return (32'(st) << 9) | (32'(full) << 8) | (32'(pend) << 1) | 32'(run);
  endfunction

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'((ch << 2) | sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'((ch << 2) | sel);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic set_busy(input int ch, input bit v);
    @(negedge clk);
    busy_i[ch] = v;
    @(negedge clk);
  endtask

  task automatic pulse(input int ch, input bit is_push);
    @(negedge clk);
    if (is_push) push_i[ch] = 1'b1; else pop_i[ch] = 1'b1;
    @(negedge clk);
    push_i[ch] = 1'b0; pop_i[ch] = 1'b0;
  endtask

  function automatic int st_of(input int ch);
    return int'(state_o[2*ch +: 2]);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < NUM_CH; c++) chk("R1 state", 32'(st_of(c)), 32'd3);
    chk("R1 run", 32'(run_o), 32'd0);
    chk("R1 full", 32'(full_o), 32'd0);
    chk("R1 prio", 32'(prio_o), 32'd0);
    rd(0, 3, d); chk("R1 R3 control word", d, cw(3, 0, 0, 0));
    rd(2, 1, d); chk("R1 final index", d, 32'd0);
  endtask

  task automatic t_enable_follow;
    logic [31:0] d;
    wr(0, 3, 32'h1);
    chk("R4 run", 32'(run_o[0]), 32'd1);
    chk("R4 idle", 32'(st_of(0)), 32'd0);
    chk("R2 other channel untouched", 32'(st_of(1)), 32'd3);
    set_busy(0, 1);
    chk("R5 busy", 32'(st_of(0)), 32'd1);
    rd(0, 3, d); chk("R3 busy word", d, cw(1, 0, 0, 1));
    set_busy(0, 0);
    chk("R5 back idle", 32'(st_of(0)), 32'd0);
  endtask

  task automatic t_stop;
    set_busy(0, 1);
    wr(0, 3, 32'h0);
    chk("R6 run dropped", 32'(run_o[0]), 32'd0);
    chk("R6 still busy", 32'(st_of(0)), 32'd1);
    @(negedge clk);
    chk("R6 held busy", 32'(st_of(0)), 32'd1);
    set_busy(0, 0);
    chk("R6 stopped after drain", 32'(st_of(0)), 32'd2);
    wr(0, 3, 32'h1);
    wr(0, 3, 32'h0);
    chk("R6 immediate stop", 32'(st_of(0)), 32'd2);
  endtask

  task automatic t_restart_cancels;
    wr(0, 3, 32'h1);
    set_busy(0, 1);
    wr(0, 3, 32'h2);
    chk("R7 clear pending busy", 32'(st_of(0)), 32'd1);
    wr(0, 3, 32'h1);
    chk("R8 run back", 32'(run_o[0]), 32'd1);
    set_busy(0, 0);
    chk("R8 idle not cleared", 32'(st_of(0)), 32'd0);
  endtask

  task automatic t_queue_clear;
    logic [31:0] d;
    wr(1, 1, 32'd1);
    rd(1, 1, d); chk("R2 final readback", d, 32'd1);
    wr(1, 3, 32'h1);
    pulse(1, 1);
    chk("R9 one of two", 32'(full_o[1]), 32'd0);
    pulse(1, 1);
    chk("R9 full", 32'(full_o[1]), 32'd1);
    rd(1, 3, d); chk("R3 full word", d, cw(0, 1, 0, 1));
    pulse(1, 1);
    pulse(1, 0);
    chk("R9 push into full dropped", 32'(full_o[1]), 32'd0);
    pulse(1, 1);
    chk("R9 refilled", 32'(full_o[1]), 32'd1);
    set_busy(1, 1);
    wr(1, 3, 32'h3);
    chk("R7 run dropped", 32'(run_o[1]), 32'd0);
    rd(1, 3, d); chk("R7 pending word", d, cw(1, 1, 1, 0));
    set_busy(1, 0);
    chk("R7 cleared", 32'(st_of(1)), 32'd3);
    chk("R7 queue emptied", 32'(full_o[1]), 32'd0);
    rd(1, 3, d); chk("R7 cleared word", d, cw(3, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk("R7 clear sticky", 32'(st_of(1)), 32'd3);
    wr(1, 3, 32'h1);
    pulse(1, 1);
    chk("R9 not full after clear", 32'(full_o[1]), 32'd0);
    pulse(1, 1);
    chk("R9 full again", 32'(full_o[1]), 32'd1);
  endtask

  task automatic t_halted_push;
    wr(2, 3, 32'h0);
    chk("R6 idle stop", 32'(st_of(2)), 32'd2);
    pulse(2, 1);
    chk("R9 halted push not full", 32'(full_o[2]), 32'd0);
    wr(2, 3, 32'h1);
    chk("R9 halted push not counted", 32'(full_o[2]), 32'd0);
    pulse(2, 1);
    chk("R9 single entry window full", 32'(full_o[2]), 32'd1);
    wr(2, 0, 32'd5);
    chk("R9 final below first is full", 32'(full_o[2]), 32'd1);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(3, 2, 32'h1);
    chk("R10 prio set", 32'(prio_o), 32'h8);
    rd(3, 2, d); chk("R10 prio readback", d, 32'd1);
    wr(3, 2, 32'h2);
    chk("R10 prio bit0 only", 32'(prio_o), 32'h0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    busy_i = '0; push_i = '0; pop_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_follow();
    t_stop();
    t_restart_cancels();
    t_queue_clear();
    t_halted_push();
    t_prio();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule